// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the programmable divider in the feedback path of an integer-N frequency synthesizer. Its input clock is already at half the oscillator frequency. The block divides that clock by a whole number between 220 and 227, and a 3-bit channel number picks the value. Each complete division produces one output pulse for the phase detector.

Inside there is a dual-modulus prescaler that divides by 22 or 23, and one shared 4-bit counter. The counter counts prescaler periods. Each division cycle opens in a swallow phase, in which the prescaler divides by 23. The cycle moves to a program phase, in which the prescaler divides by 22, as soon as the low three bits of the counter equal the channel number that was captured for this cycle. After ten prescaler periods the counter returns to zero and the next cycle begins. The total is 220 plus the number of 23-long periods, and that number equals the channel value.

The channel number is captured only at cycle boundaries, so changing the channel never produces a shortened or lengthened cycle. The prescaler is itself a small state machine. Its BASE state counts the first 22 input clocks of a period. Its EXTRA state adds one more clock when the swallow phase requests divide-by-23. The sequencer has two states: SWALLOW, which is left on a counter match, and PROGRAM, which is held until the tenth period ends.

Top module: `pulse_swallow_div`

## Requirements
- R1: The number of input clock cycles between consecutive `div_out` pulses is 220 + CH, where CH is the 3-bit unsigned value captured from `ch_sel`.
- R2: With CH = 0, every prescaler period is 22 cycles long and the division cycle is exactly 220 cycles.
- R3: With CH = 7, the division cycle is exactly 227 cycles.
- R4: `ch_sel` is captured only at the clock edge that ends a division cycle. Any number of changes during a cycle leave that cycle's length unchanged, and only the value present at the boundary edge sets the next cycle.
- R5: `div_out` is high for exactly one input clock cycle per division cycle.
- R6: While the synchronous active-high `rst` is held, `div_out` and `pre_pulse` are low, the counters are cleared, and `mod_high` shows whether the captured channel is non-zero. The first cycle after release is a full 220 + CH cycles long.
- R7: In each division cycle the first CH prescaler periods are 23 cycles long and the remaining ones are 22 cycles long. `mod_high` is 1 in the 23-long periods and changes only at a prescaler period boundary.
- R8: Each division cycle holds exactly ten prescaler periods. `div_out` rises on the cycle after the tenth `pre_pulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock at half the oscillator frequency |
| rst | input | 1 | Synchronous active-high reset |
| ch_sel | input | 3 | Channel number CH; the ratio is 220 + CH |
| div_out | output | 1 | One-cycle pulse at each division cycle boundary |
| pre_pulse | output | 1 | High on the last input cycle of each prescaler period |
| mod_high | output | 1 | 1 while the prescaler divides by 23, 0 while it divides by 22 |

## Verification
Every channel value from 0 to 7 is held for several cycles. The CH = 0 and CH = 7 runs separate a sequencer that never enters the swallow phase, or never leaves it, from one that switches correctly. The length of each prescaler period is measured as well as the length of each full cycle, so an error in the switching point is reported even when some other error would cancel it in the total. Channel changes are placed at many offsets inside a cycle, including two changes in the same cycle, which shows whether the design captures the channel at the boundary or follows it live. A reset applied in the middle of a cycle, while the channel changes, checks the cleared state and the length of the first cycle after release.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Prescaler period state: BASE counts the common part, EXTRA adds one clock.
    typedef enum logic [0:0] {
        PS_BASE  = 1'b0,
        PS_EXTRA = 1'b1
    } pre_state_e;

    // Division cycle phase: SWALLOW uses the high modulus, PROGRAM the low one.
    typedef enum logic [0:0] {
        PH_SWALLOW = 1'b0,
        PH_PROGRAM = 1'b1
    } cyc_phase_e;

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int unsigned MOD_LO = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic mod_hi,
    output logic tick
);
    localparam int unsigned PC_W = $clog2(MOD_LO);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(MOD_LO - 1);

    pre_state_e      st;
    logic [PC_W-1:0] pc;

    // State register: BASE counts 0..MOD_LO-1; EXTRA is visited only for the high modulus.
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= PS_BASE;
            pc <= '0;
        end else begin
            unique case (st)
                PS_BASE: begin
                    if (pc == PC_LAST) begin
                        if (mod_hi) begin
                            st <= PS_EXTRA;
                        end else begin
                            pc <= '0;
                        end
                    end else begin
                        pc <= pc + 1'b1;
                    end
                end
                PS_EXTRA: begin
                    st <= PS_BASE;
                    pc <= '0;
                end
                default: begin
                    st <= PS_BASE;
                    pc <= '0;
                end
            endcase
        end
    end

    // Output decode: tick marks the last input cycle of the period.
    always_comb begin
        tick = 1'b0;
        unique case (st)
            PS_BASE:  tick = (pc == PC_LAST) && !mod_hi;
            PS_EXTRA: tick = 1'b1;
            default:  tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/psd_swallow_fsm.sv
module psd_swallow_fsm
    import psd_pkg::*;
#(
    parameter int unsigned PROG_N = 10,
    parameter int unsigned CH_W   = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [CH_W-1:0]             ch,
    input  logic                        tick,
    output logic                        mod_hi,
    output logic                        div_q,
    output logic                        wrap,
    output logic [$clog2(PROG_N)-1:0]   cyc_idx,
    output logic [CH_W-1:0]             ch_held
);
    localparam int unsigned CNT_W = $clog2(PROG_N);
    localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(PROG_N - 1);

    cyc_phase_e       ph;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] idx_nxt;
    logic [CH_W-1:0]  ch_q;
    logic             match;
    logic             last;

    assign idx_nxt = idx + 1'b1;
    assign last    = (idx == IDX_LAST);
    assign wrap    = tick && last;

    // Compare the low bits of the next period index with the captured channel.
    generate
        if (CNT_W >= CH_W) begin : g_wide_cnt
            assign match = (idx_nxt[CH_W-1:0] == ch_q);
        end else begin : g_narrow_cnt
            assign match = (CH_W'(idx_nxt) == ch_q);
        end
    endgenerate

    // State register: phase, period index and captured channel.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            ch_q <= ch;
            ph   <= (ch == '0) ? PH_PROGRAM : PH_SWALLOW;
        end else if (tick) begin
            if (last) begin
                idx  <= '0;
                ch_q <= ch;
                ph   <= (ch == '0) ? PH_PROGRAM : PH_SWALLOW;
            end else begin
                idx <= idx_nxt;
                unique case (ph)
                    PH_SWALLOW: if (match) ph <= PH_PROGRAM;
                    PH_PROGRAM: ph <= PH_PROGRAM;
                    default:    ph <= PH_PROGRAM;
                endcase
            end
        end
    end

    // Output register: one-cycle boundary pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= 1'b0;
        end else begin
            div_q <= wrap;
        end
    end

    assign mod_hi  = (ph == PH_SWALLOW);
    assign cyc_idx = idx;
    assign ch_held = ch_q;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int unsigned CH_W    = 3,
    parameter int unsigned PRE_MOD = 22,
    parameter int unsigned PROG_N  = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CH_W-1:0] ch_sel,
    output logic            div_out,
    output logic            pre_pulse,
    output logic            mod_high
);
    localparam int unsigned CNT_W = $clog2(PROG_N);

    logic             tick;
    logic             mod_hi;
    logic             wrap;
    logic [CNT_W-1:0] cyc_idx;
    logic [CH_W-1:0]  ch_held;

    psd_prescaler #(
        .MOD_LO (PRE_MOD)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .mod_hi (mod_hi),
        .tick   (tick)
    );

    psd_swallow_fsm #(
        .PROG_N (PROG_N),
        .CH_W   (CH_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .ch      (ch_sel),
        .tick    (tick),
        .mod_hi  (mod_hi),
        .div_q   (div_out),
        .wrap    (wrap),
        .cyc_idx (cyc_idx),
        .ch_held (ch_held)
    );

    assign pre_pulse = tick;
    assign mod_high  = mod_hi;

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int unsigned CH_W   = 3,
    parameter int unsigned PROG_N = 10,
    parameter int unsigned CNT_W  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             div_out,
    input logic             pre_pulse,
    input logic             mod_high,
    input logic [CNT_W-1:0] cyc_idx,
    input logic [CH_W-1:0]  ch_held
);

    // R5: the boundary pulse never lasts two cycles
    a_r5_one_wide: assert property (@(posedge clk) disable iff (rst)
        div_out |=> !div_out);

    // R8: the pulse follows the prescaler tick that ends the tenth period
    a_r8_after_last_period: assert property (@(posedge clk) disable iff (rst)
        div_out |-> ($past(pre_pulse) && ($past(cyc_idx) == CNT_W'(PROG_N - 1))));

    // R8: the period index stays inside its range
    a_r8_idx_range: assert property (@(posedge clk) disable iff (rst)
        cyc_idx < CNT_W'(PROG_N));

    // R4: the captured channel changes only together with the boundary pulse
    a_r4_channel_held: assert property (@(posedge clk) disable iff (rst)
        (!div_out && !$past(rst)) |-> $stable(ch_held));

    // R7: the modulus changes only at a prescaler period boundary
    a_r7_mod_at_boundary: assert property (@(posedge clk) disable iff (rst)
        (!$past(pre_pulse) && !$past(rst)) |-> $stable(mod_high));

    // R7: the swallow phase is entered only at the start of a cycle
    a_r7_swallow_at_start: assert property (@(posedge clk) disable iff (rst)
        ($rose(mod_high) && !$past(rst)) |-> div_out);

endmodule

bind pulse_swallow_div psd_checker #(
    .CH_W   (CH_W),
    .PROG_N (PROG_N),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .div_out   (div_out),
    .pre_pulse (pre_pulse),
    .mod_high  (mod_high),
    .cyc_idx   (cyc_idx),
    .ch_held   (ch_held)
);

// File: tb/test_pulse_swallow_div.sv
`timescale 1ns/1ps
module test_pulse_swallow_div;
    localparam int CH_W = 3;
    localparam int PRE  = 22;
    localparam int PN   = 10;
    localparam int BASE = PRE * PN;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [CH_W-1:0] ch  = 3'd3;
    logic            div_out;
    logic            pre_pulse;
    logic            mod_high;

    always #2.5 clk = ~clk;

    pulse_swallow_div i_pulse_swallow_div (
        .clk       (clk),
        .rst       (rst),
        .ch_sel    (ch),
        .div_out   (div_out),
        .pre_pulse (pre_pulse),
        .mod_high  (mod_high)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor state, all sampled at the falling edge
    bit              rst_prev = 1'b1;
    bit              out_prev = 1'b0;
    bit              armed    = 1'b0;
    bit              first    = 1'b0;
    bit              chg      = 1'b0;
    logic [CH_W-1:0] ch_prev  = 3'd3;
    int              out_cnt, pre_cnt, k, ch_cur, exp_pre;
    bit [7:0]        seen = '0;
    string           tag;

    always @(negedge clk) begin
        if (rst) begin
            if (rst_prev) begin
                chk(div_out == 1'b0, "R6 reset div_out", int'(div_out), 0);
                chk(pre_pulse == 1'b0, "R6 reset pre_pulse", int'(pre_pulse), 0);
                chk(mod_high == (ch_prev != 0), "R6 reset mod_high",
                    int'(mod_high), int'(ch_prev != 0));
            end
            armed = 1'b0;
        end else if (!armed) begin
            armed   = 1'b1;
            out_cnt = 0;
            pre_cnt = 1;
            k       = 0;
            ch_cur  = int'(ch_prev);
            first   = 1'b1;
            chg     = 1'b0;
        end else begin
            out_cnt++;
            pre_cnt++;
            if (out_prev) chk(!div_out, "R5 pulse width", int'(div_out), 0);
            if (pre_pulse) begin
                exp_pre = (k < ch_cur) ? PRE + 1 : PRE;
                chk(pre_cnt == exp_pre, "R7 prescaler period", pre_cnt, exp_pre);
                pre_cnt = 0;
                k++;
            end
            if (div_out) begin
                chk(k == PN, "R8 periods per cycle", k, PN);
                if (first)            tag = "R6 first cycle";
                else if (chg)         tag = "R4 mid-cycle change";
                else if (ch_cur == 0) tag = "R2 channel 0";
                else if (ch_cur == 7) tag = "R3 channel 7";
                else                  tag = "R1 ratio";
                chk(out_cnt == BASE + ch_cur, tag, out_cnt, BASE + ch_cur);
                seen[ch_cur] = 1'b1;
                ch_cur  = int'(ch_prev);
                k       = 0;
                out_cnt = 0;
                first   = 1'b0;
                chg     = 1'b0;
            end else if (ch != ch_prev) begin
                chg = 1'b1;
            end
        end
        ch_prev  = ch;
        rst_prev = rst;
        out_prev = div_out;
    end

    task automatic wait_out(input int n);
        repeat (n) begin
            do @(negedge clk); while (!div_out);
        end
    endtask

    task automatic set_ch_after(input int off, input int val);
        @(posedge clk);
        repeat (off) @(posedge clk);
        #1 ch = CH_W'(val);
    endtask

    initial begin
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        wait_out(2);
        // R1 R2 R3: sweep every channel value
        for (int c = 0; c < 8; c++) begin
            wait_out(1);
            set_ch_after(c * 20, c);
            wait_out(3);
        end
        // R4: one or two changes inside a cycle at varied offsets
        for (int i = 0; i < 12; i++) begin
            wait_out(1);
            set_ch_after((i * 37) % 200, (i * 5 + 3) % 8);
            if (i % 2 == 1) set_ch_after(15, (i * 3 + 1) % 8);
            wait_out(1);
        end
        // R6: reset in the middle of a cycle, channel changed while held
        wait_out(1);
        repeat (90) @(posedge clk);
        #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 ch = 3'd7;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        wait_out(3);
        repeat (3) @(posedge clk);
        for (int c = 0; c < 8; c++) chk(seen[c], "R1 channel covered", int'(seen[c]), 1);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule